// File: doc/BRIEF.md
# Frame-Sync Serial Audio Byte Receiver

This block listens to a serial audio stream in which the codec is the clock master: it drives a bit clock, a word clock whose rising edge marks the start of each frame, and one serial data line. Each frame carries the left-channel word first and then the right-channel word, most significant bit first. The word length may be 16, 20, 24 or 32 bits. The receiver brings all three lines into its own faster system clock domain. It detects the frame start and skips a programmable number of bit-clock sampling edges. It then shifts in the next 8 bits and presents them as one byte.

The intended use is low-rate speech, such as 8 kHz mono, where the codec places a companded 8-bit sample in the top byte of the left word. One byte is produced per frame. The rest of the left word and the whole right word are discarded. A frame start that arrives before the byte is complete discards the partial byte, restarts capture and sets a sticky error flag.

The output is a stream without back-pressure, because the codec cannot be stalled. `out_valid` is high for exactly one system cycle per byte, and the consumer must take `out_data` in that cycle. `out_data` then holds its value until the next byte, so a slow consumer can still read it for roughly one frame.

Top module: `dsp_audio_byte_rx`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `out_valid` is 0, `frame_err` is 0 and `out_data` is 0.
- R2: A rising edge on `wclk_in` starts a frame. After the skipped edges, the next 8 sampling edges supply the byte, and the first of these lands in `out_data[7]` (MSB first).
- R3: `cfg_offset` (0 to 31) sets how many sampling edges after the frame start are skipped before capture begins. A value of 0 captures from the first sampling edge after the frame start.
- R4: `cfg_sample_falling` selects the sampling edge: 0 samples `sdata_in` on rising edges of `bclk_in`, and 1 samples on falling edges.
- R5: Exactly one byte is produced per complete frame. Sampling edges after the 8th captured bit, including the whole right word, change neither `out_valid` nor `out_data` until the next frame start.
- R6: `out_valid` is high for one system cycle per byte. `out_data` changes only in a cycle where `out_valid` is high and is held otherwise. No ready input exists.
- R7: A frame start that arrives after a frame start but before the 8th bit is captured discards the partial byte, restarts capture for the new frame and sets `frame_err`. `frame_err` stays set until reset.
- R8: A frame start that arrives after a completed byte, or the first frame start after reset, does not set `frame_err`.
- R9: Capture does not depend on the word length. Frames with 16, 20, 24 and 32-bit words yield the top byte of the left word without any word-length setting.
- R10: `out_valid` rises at the third rising edge of `clk` after the input edge that sampled the 8th bit, and not earlier. A sampling edge detected in the same system cycle as a frame start is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4 times the bit-clock rate |
| rst | input | 1 | Synchronous active-high reset |
| bclk_in | input | 1 | Bit clock from the codec, asynchronous |
| wclk_in | input | 1 | Word clock / frame sync from the codec, asynchronous |
| sdata_in | input | 1 | Serial audio data from the codec, asynchronous |
| cfg_sample_falling | input | 1 | 0: sample on bit-clock rising edge; 1: on falling edge |
| cfg_offset | input | 5 | Sampling edges skipped after the frame start |
| out_data | output | 8 | Captured byte, held until the next byte |
| out_valid | output | 1 | One-cycle strobe for a new byte |
| frame_err | output | 1 | Sticky flag for a frame cut short before its byte |

## Verification
A wrong skip or bit count shows up as a shifted or rotated byte on `out_data` at the end of the first affected frame. A stuck capture state shows up as a missing strobe or a second strobe in the same frame, which a per-frame strobe count catches within one frame. An error flag that is never set, or one that clears by itself, is visible on `frame_err` one frame after an early frame start. Edge-detection latency is checked cycle by cycle against the edge that samples the last bit.

// File: rtl/dspa_rx_pkg.sv
package dspa_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SKIP,
    ST_CAPT,
    ST_DONE
  } rx_state_e;
endpackage

// File: rtl/dspa_sync.sv
// Multi-stage synchroniser for a vector of asynchronous lines.
module dspa_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= async_in;
      for (int i = 1; i < STAGES; i++) begin
        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/dspa_frame_ctrl.sv
// Frame sequencing: skip offset, count captured bits, flag short frames.
module dspa_frame_ctrl
  import dspa_rx_pkg::*;
#(
  parameter int OFF_W  = 5,
  parameter int BYTE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fs_pulse,
  input  logic             smp_pulse,
  input  logic [OFF_W-1:0] cfg_offset,
  output logic             cap_en,
  output logic             cap_last,
  output logic             cap_clear,
  output logic             err_flag
);
  localparam int BIT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  rx_state_e        state_q;
  logic [OFF_W-1:0] skip_q;
  logic [BIT_W-1:0] bit_q;
  logic             skip_end;

  assign skip_end = ({1'b0, skip_q} + 1'b1) == {1'b0, cfg_offset};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      skip_q   <= '0;
      bit_q    <= '0;
      err_flag <= 1'b0;
    end else if (fs_pulse) begin
      if (state_q == ST_SKIP || state_q == ST_CAPT) begin
        err_flag <= 1'b1;
      end
      skip_q  <= '0;
      bit_q   <= '0;
      state_q <= (cfg_offset == '0) ? ST_CAPT : ST_SKIP;
    end else if (smp_pulse) begin
      case (state_q)
        ST_SKIP: begin
          if (skip_end) begin
            skip_q  <= '0;
            state_q <= ST_CAPT;
          end else begin
            skip_q <= skip_q + 1'b1;
          end
        end
        ST_CAPT: begin
          if (bit_q == LAST_BIT) begin
            bit_q   <= '0;
            state_q <= ST_DONE;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
        default: begin
          state_q <= state_q;
        end
      endcase
    end
  end

  assign cap_en    = smp_pulse && !fs_pulse && (state_q == ST_CAPT);
  assign cap_last  = cap_en && (bit_q == LAST_BIT);
  assign cap_clear = fs_pulse;
endmodule

// File: rtl/dspa_capture.sv
// MSB-first shift register and byte output register.
module dspa_capture #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              cap_en,
  input  logic              cap_last,
  input  logic              bit_in,
  output logic [BYTE_W-1:0] data_out,
  output logic              valid_out
);
  logic [BYTE_W-1:0] shift_q;
  logic [BYTE_W-1:0] shift_nxt;

  assign shift_nxt = {shift_q[BYTE_W-2:0], bit_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q   <= '0;
      data_out  <= '0;
      valid_out <= 1'b0;
    end else begin
      valid_out <= 1'b0;
      if (clear) begin
        shift_q <= '0;
      end else if (cap_en) begin
        shift_q <= shift_nxt;
        if (cap_last) begin
          data_out  <= shift_nxt;
          valid_out <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dsp_audio_byte_rx.sv
module dsp_audio_byte_rx #(
  parameter int OFF_W       = 5,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bclk_in,
  input  logic              wclk_in,
  input  logic              sdata_in,
  input  logic              cfg_sample_falling,
  input  logic [OFF_W-1:0]  cfg_offset,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_valid,
  output logic              frame_err
);
  localparam int N_LINES = 3;
  localparam int IDX_B   = 0;
  localparam int IDX_W   = 1;
  localparam int IDX_D   = 2;

  logic [N_LINES-1:0] lines_s;
  logic               bclk_q;
  logic               wclk_q;
  logic               bclk_rise;
  logic               bclk_fall;
  logic               fs_pulse;
  logic               smp_pulse;
  logic               cap_en;
  logic               cap_last;
  logic               cap_clear;

  dspa_sync #(
    .W      (N_LINES),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in ({sdata_in, wclk_in, bclk_in}),
    .sync_out (lines_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_q <= 1'b0;
      wclk_q <= 1'b0;
    end else begin
      bclk_q <= lines_s[IDX_B];
      wclk_q <= lines_s[IDX_W];
    end
  end

  assign bclk_rise = lines_s[IDX_B] && !bclk_q;
  assign bclk_fall = !lines_s[IDX_B] && bclk_q;
  assign fs_pulse  = lines_s[IDX_W] && !wclk_q;
  assign smp_pulse = cfg_sample_falling ? bclk_fall : bclk_rise;

  dspa_frame_ctrl #(
    .OFF_W  (OFF_W),
    .BYTE_W (BYTE_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .fs_pulse   (fs_pulse),
    .smp_pulse  (smp_pulse),
    .cfg_offset (cfg_offset),
    .cap_en     (cap_en),
    .cap_last   (cap_last),
    .cap_clear  (cap_clear),
    .err_flag   (frame_err)
  );

  dspa_capture #(
    .BYTE_W (BYTE_W)
  ) u_cap (
    .clk       (clk),
    .rst       (rst),
    .clear     (cap_clear),
    .cap_en    (cap_en),
    .cap_last  (cap_last),
    .bit_in    (lines_s[IDX_D]),
    .data_out  (out_data),
    .valid_out (out_valid)
  );
endmodule

// File: rtl/dspa_rx_checker.sv
module dspa_rx_checker #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [BYTE_W-1:0] out_data,
  input logic              out_valid,
  input logic              frame_err
);
  // R1: the cycle after reset shows the idle outputs
  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !frame_err && out_data == '0));

  // R6: strobe lasts a single cycle
  p_single_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R6: byte register only moves together with the strobe
  p_data_held_r6: assert property (@(posedge clk) disable iff (rst)
    (out_data != $past(out_data)) |-> out_valid);

  // R7: error flag is sticky
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    frame_err |=> frame_err);
endmodule

bind dsp_audio_byte_rx dspa_rx_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .out_data  (out_data),
  .out_valid (out_valid),
  .frame_err (frame_err)
);

// File: tb/dsp_audio_byte_rx_bench.sv
`timescale 1ns/1ps
module dsp_audio_byte_rx_bench;
  localparam int HB = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bclk_in = 1'b1;
  logic       wclk_in = 1'b0;
  logic       sdata_in = 1'b0;
  logic       cfg_sample_falling = 1'b0;
  logic [4:0] cfg_offset = '0;
  logic [7:0] out_data;
  logic       out_valid;
  logic       frame_err;

  int checks = 0;
  int errors = 0;
  int vcount = 0;
  logic [7:0] last_byte = '0;

  always #2 clk = ~clk;

  dsp_audio_byte_rx u_dsp_audio_byte_rx (
    .clk                (clk),
    .rst                (rst),
    .bclk_in            (bclk_in),
    .wclk_in            (wclk_in),
    .sdata_in           (sdata_in),
    .cfg_sample_falling (cfg_sample_falling),
    .cfg_offset         (cfg_offset),
    .out_data           (out_data),
    .out_valid          (out_valid),
    .frame_err          (frame_err)
  );

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      vcount    <= vcount + 1;
      last_byte <= out_data;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Drives one frame; data launched on the non-sampling edge.
  task automatic run_frame(input int off, input bit fall, input int wl,
                           input logic [31:0] left, input logic [31:0] right,
                           input int nslots, input bit tchk);
    for (int s = 0; s < nslots; s++) begin
      int idx;
      logic b;
      idx = s - off;
      if (idx < 0) b = s[0] ^ 1'b1;
      else if (idx < wl) b = left[31 - idx];
      else if (idx < 2 * wl) b = right[31 - (idx - wl)];
      else b = 1'b0;
      bclk_in  = fall ? 1'b1 : 1'b0;
      sdata_in = b;
      wclk_in  = (s == 0);
      repeat (HB) @(negedge clk);
      bclk_in = fall ? 1'b0 : 1'b1;
      if (tchk && s == off + 7) begin
        repeat (2) @(posedge clk);
        #1 chk(out_valid == 1'b0, "R10", "strobe too early", out_valid, 0);
        @(posedge clk);
        #1 chk(out_valid == 1'b1, "R10", "strobe at 3rd edge", out_valid, 1);
        repeat (HB - 2) @(negedge clk);
      end else begin
        repeat (HB) @(negedge clk);
      end
    end
    wclk_in = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic setup(input int off, input bit fall);
    @(negedge clk);
    cfg_offset         = 5'(off);
    cfg_sample_falling = fall;
    bclk_in            = fall ? 1'b0 : 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic good_frame(input string req, input int off, input bit fall,
                            input int wl, input logic [31:0] left,
                            input logic [31:0] right);
    int v0;
    setup(off, fall);
    v0 = vcount;
    run_frame(off, fall, wl, left, right, 2 * wl, 1'b1);
    chk(vcount - v0 == 1, req, "bytes per frame", vcount - v0, 1);
    chk(last_byte == left[31:24], req, "captured byte", last_byte, left[31:24]);
    chk(out_data == left[31:24], req, "held byte", out_data, left[31:24]);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 0, "R1", "valid after reset", out_valid, 0);
    chk(frame_err == 0, "R1", "err after reset", frame_err, 0);
    chk(out_data == 0, "R1", "data after reset", out_data, 0);
  endtask

  task automatic t_basic;
    good_frame("R2", 0, 1'b0, 16, 32'hA5C3_0000, 32'hFFFF_0000);
  endtask

  task automatic t_offsets;
    good_frame("R3", 3, 1'b1, 32, 32'h3C12_3456, 32'hC3C3_C3C3);
    good_frame("R4", 0, 1'b1, 20, 32'h5A7F_F000, 32'hAAAA_A000);
    good_frame("R9", 1, 1'b0, 24, 32'h8100_FF00, 32'h7E7E_7E00);
    good_frame("R3", 31, 1'b0, 32, 32'hE719_2B3C, 32'h0F0F_0F0F);
  endtask

  task automatic t_ignore_tail;
    logic [7:0] d0;
    int v0;
    d0 = out_data;
    v0 = vcount;
    repeat (40) @(negedge clk);
    chk(out_data == d0, "R6", "byte held while idle", out_data, d0);
    chk(vcount == v0, "R5", "no strobe outside frame", vcount, v0);
    chk(frame_err == 0, "R8", "no err after full frames", frame_err, 0);
  endtask

  task automatic t_early_sync;
    int v0;
    setup(2, 1'b0);
    v0 = vcount;
    run_frame(2, 1'b0, 16, 32'hFFFF_0000, 32'h0, 7, 1'b0);
    chk(vcount == v0, "R7", "no byte from short frame", vcount, v0);
    chk(frame_err == 0, "R7", "err before next sync", frame_err, 0);
    run_frame(2, 1'b0, 16, 32'h9600_0000, 32'hFFFF_0000, 32, 1'b1);
    chk(vcount - v0 == 1, "R7", "restart yields one byte", vcount - v0, 1);
    chk(last_byte == 8'h96, "R7", "restarted byte", last_byte, 8'h96);
    chk(frame_err == 1, "R7", "err set by early sync", frame_err, 1);
    good_frame("R7", 0, 1'b1, 16, 32'h1E00_0000, 32'h0);
    chk(frame_err == 1, "R7", "err stays set", frame_err, 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_offsets();
    t_ignore_tail();
    t_early_sync();
    t_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule